// File: doc/BRIEF.md
# Power-Fail Guarded SRAM Controller

This block turns single-cycle host requests into correctly ordered strobe sequences for an asynchronous, byte-wide static RAM. It drives an active-low chip enable, write enable and output enable, a 21-bit address and an 8-bit bidirectional data bus. The host raises a request with a read/write flag, an address and write data. The controller returns a one-cycle completion pulse and, for reads, the captured byte. Three parameters set how many clock cycles the address setup, the strobe and the hold phases each last, so the memory's access-time limits can be met at any clock rate.

An external comparator feeds a supply-fail input. The controller synchronises this input. It then drops every strobe within a few clocks and abandons any access that is in progress. It refuses new work until a recovery interval has run out after the supply returns. The interval length comes from the clock frequency in kHz and the recovery time in microseconds. The same lockout also runs once after reset.

Top module: `sramc_top`

## Requirements
- R1: While reset is asserted and right after it, the chip enable, write enable and output enable outputs are high (inactive), the data bus is released (high-impedance) and busy is high.
- R2: A write raises no strobe for SETUP_CYC cycles. Chip enable and write enable then fall together, stay low for exactly STROBE_CYC cycles and rise together. Output enable stays high for the whole write.
- R3: A read holds write enable high throughout. It drives chip enable and output enable low together for STROBE_CYC cycles. The returned byte is the value on the data bus in the final strobe cycle.
- R4: The controller drives the data bus only during the strobe cycles of a write and for one cycle after them. It never drives the bus while output enable is low.
- R5: Completion is a single-cycle pulse. When the request is driven one cycle and accepted at clock edge n, completion is high after edge n+SETUP_CYC+STROBE_CYC+HOLD_CYC.
- R6: Once the supply-fail input is high, all three strobes are high no later than the third rising clock edge. An interrupted access produces no completion pulse.
- R7: Busy stays high, and no request is accepted, while supply-fail is high and for RECOVER_CYC = CLK_KHZ*RECOVER_US/1000 cycles after it returns low. The same lockout is applied after reset. Busy falls at most four cycles after that count.
- R8: A request raised while busy is high is dropped. It causes no strobe and no memory change.
- R9: The address bus carries the accepted address unchanged while chip enable is low. Every location of the address space can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Supply-fail flag from the external comparator (asynchronous) |
| req_valid_i | input | 1 | Request strobe, sampled when busy is low |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write byte |
| req_busy_o | output | 1 | Access in progress or lockout active |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Byte returned by the last read |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_io | inout | DATA_W | Bidirectional data bus |

## Verification
The bench builds the controller with a 6-bit address, phase counts of 2, 3 and 1 cycles, and a 1000 kHz clock setting with a 24 µs recovery, which gives a 24-cycle lockout. With a 64-byte space, the bench can write and read back every location with distinct data, and it can time each access exactly. With the short lockout, it can drop the supply in the middle of a write and in the middle of a read, probe the lockout with stray requests and measure the recovery, all within a short run.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_LOCKOUT
    } seq_state_e;
endpackage

// File: rtl/sramc_guard.sv
module sramc_guard #(
    parameter int unsigned RECOVER_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail_i,
    output logic fail_o,
    output logic lock_o
);
    localparam int unsigned CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(RECOVER_CYC);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.sync = {g_q.sync[0], pwr_fail_i};
        if (g_q.sync[1]) begin
            g_d.cnt = RELOAD;
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.sync <= '0;
            g_q.cnt  <= RELOAD;
        end else begin
            g_q <= g_d;
        end
    end

    assign fail_o = g_q.sync[1];
    assign lock_o = g_q.sync[1] || (g_q.cnt != '0);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= RELOAD)
        else $error("recovery counter above reload value");
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned STROBE_CYC = 9,
    parameter int unsigned HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_i,
    input  logic              lock_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] dq_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o
);
    localparam int unsigned MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int unsigned MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int unsigned CNTW  = $clog2(MAX_C + 1);
    localparam logic [CNTW-1:0] SETUP_LD  = CNTW'(SETUP_CYC - 1);
    localparam logic [CNTW-1:0] STROBE_LD = CNTW'(STROBE_CYC - 1);
    localparam logic [CNTW-1:0] HOLD_LD   = CNTW'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNTW-1:0]   cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (lock_i) begin
                    s_d.st = ST_LOCKOUT;
                end else if (req_valid_i) begin
                    s_d.st    = ST_SETUP;
                    s_d.cnt   = SETUP_LD;
                    s_d.wr    = req_write_i;
                    s_d.addr  = req_addr_i;
                    s_d.wdata = req_wdata_i;
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_STROBE;
                    s_d.cnt = STROBE_LD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (s_q.cnt == '0) begin
                    if (!s_q.wr) s_d.rdata = dq_in_i;
                    s_d.st  = ST_HOLD;
                    s_d.cnt = HOLD_LD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_LOCKOUT: begin
                if (!lock_i) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_LOCKOUT;
        endcase

        if (fail_i) begin
            s_d.st   = ST_LOCKOUT;
            s_d.done = 1'b0;
        end

        s_d.ce_n  = (s_d.st != ST_STROBE);
        s_d.we_n  = !((s_d.st == ST_STROBE) && s_d.wr);
        s_d.oe_n  = !((s_d.st == ST_STROBE) && !s_d.wr);
        s_d.dq_oe = s_d.wr && ((s_d.st == ST_STROBE) || (s_q.st == ST_STROBE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_LOCKOUT;
            s_q.ce_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = lock_i || (s_q.st != ST_IDLE);
    assign done_o   = s_q.done;
    assign rdata_o  = s_q.rdata;
    assign addr_o   = s_q.addr;
    assign ce_n_o   = s_q.ce_n;
    assign we_n_o   = s_q.we_n;
    assign oe_n_o   = s_q.oe_n;
    assign dq_out_o = s_q.wdata;
    assign dq_oe_o  = s_q.dq_oe;

    p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.we_n |-> (!s_q.ce_n && s_q.oe_n))
        else $error("write enable low outside chip enable or with output enable low");

    p_we_rises_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ce_n) |-> s_q.we_n)
        else $error("chip enable rose while write enable still low");

    p_read_we_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.oe_n |-> s_q.we_n)
        else $error("write enable low during read strobe");

    p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dq_oe |-> s_q.oe_n)
        else $error("bus driven while memory output enabled");

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done)
        else $error("completion longer than one cycle");

    p_no_accept_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> (s_q.st == ST_LOCKOUT))
        else $error("sequencer left lockout while locked");

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ce_n && $past(!s_q.ce_n)) |-> $stable(s_q.addr))
        else $error("address moved during strobe");
endmodule

// File: rtl/sramc_top.sv
module sramc_top #(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_KHZ    = 125000,
    parameter int unsigned RECOVER_US = 125000,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned STROBE_CYC = 9,
    parameter int unsigned HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_busy_o,
    output logic              rsp_done_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    inout  wire  [DATA_W-1:0] mem_dq_io
);
    localparam longint unsigned RECOVER_L =
        (longint'(CLK_KHZ) * longint'(RECOVER_US)) / 1000;
    localparam int unsigned RECOVER_CYC = (RECOVER_L < 1) ? 1 : int'(RECOVER_L);

    logic              fail_w;
    logic              lock_w;
    logic [DATA_W-1:0] dq_out_w;
    logic              dq_oe_w;

    sramc_guard #(
        .RECOVER_CYC (RECOVER_CYC)
    ) guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail_i (pwr_fail_i),
        .fail_o     (fail_w),
        .lock_o     (lock_w)
    );

    sramc_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fail_i      (fail_w),
        .lock_i      (lock_w),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .dq_in_i     (mem_dq_io),
        .busy_o      (req_busy_o),
        .done_o      (rsp_done_o),
        .rdata_o     (rsp_rdata_o),
        .addr_o      (mem_addr_o),
        .ce_n_o      (mem_ce_n_o),
        .we_n_o      (mem_we_n_o),
        .oe_n_o      (mem_oe_n_o),
        .dq_out_o    (dq_out_w),
        .dq_oe_o     (dq_oe_w)
    );

    assign mem_dq_io = dq_oe_w ? dq_out_w : {DATA_W{1'bz}};

    p_fail_strobes_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_w |=> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o))
        else $error("strobe active after supply fail");

    p_fail_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_w |=> !rsp_done_o)
        else $error("completion during supply fail");

    p_lock_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> mem_ce_n_o)
        else $error("chip enable low during lockout");

    p_lock_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |-> req_busy_o)
        else $error("busy low during lockout");
endmodule

// File: tb/sramc_top_tb_top.sv
module sramc_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int S  = 2;
    localparam int T  = 3;
    localparam int H  = 1;
    localparam int RC = 24;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_fail = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] maddr;
    logic          ce_n, we_n, oe_n;
    wire  [DW-1:0] dq;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] shadow [DEPTH];

    always #4 clk = ~clk;

    sramc_top #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_KHZ (1000), .RECOVER_US (RC),
        .SETUP_CYC (S), .STROBE_CYC (T), .HOLD_CYC (H)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pwr_fail_i (pwr_fail),
        .req_valid_i (req_valid), .req_write_i (req_write),
        .req_addr_i (req_addr), .req_wdata_i (req_wdata),
        .req_busy_o (busy), .rsp_done_o (done), .rsp_rdata_o (rdata),
        .mem_addr_o (maddr), .mem_ce_n_o (ce_n), .mem_we_n_o (we_n),
        .mem_oe_n_o (oe_n), .mem_dq_io (dq)
    );

    // memory model
    assign dq = (!ce_n && !oe_n && we_n) ? mem[maddr] : {DW{1'bz}};
    always @(posedge clk) if (!ce_n && !we_n) mem[maddr] <= dq;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-access monitor
    int  run_len, last_run, viol_order, viol_bus, viol_addr, viol_done;
    bit  saw_we, saw_oe, prev_ce_n, prev_done;
    logic [AW-1:0] exp_addr;
    always @(negedge clk) if (rst_n) begin
        if (!ce_n) begin
            run_len++;
            if (maddr !== exp_addr) viol_addr++;
            if (!we_n) saw_we = 1;
            if (!oe_n) saw_oe = 1;
        end else if (!prev_ce_n) begin
            last_run = run_len;
            run_len  = 0;
        end
        if (!we_n && (ce_n || !oe_n)) viol_order++;
        if (ce_n && prev_ce_n && dq !== {DW{1'bz}}) viol_bus++;
        if (done && prev_done) viol_done++;
        prev_ce_n = ce_n;
        prev_done = done;
    end

    task automatic access(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        int k;
        while (busy) @(negedge clk);
        exp_addr = a; saw_we = 0; saw_oe = 0; last_run = 0;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        k = 0;
        @(negedge clk); k++;
        req_valid = 0;
        while (!done && k < 40) begin @(negedge clk); k++; end
        rd = rdata;
        check(k == S + T + H + 1, "R5", "access latency", k, S + T + H + 1);
        check(last_run == T, wr ? "R2" : "R3", "strobe length", last_run, T);
        if (wr) check(saw_we && !saw_oe, "R2", "write enables", {saw_we, saw_oe}, 2);
        else    check(!saw_we && saw_oe, "R3", "read enables", {saw_we, saw_oe}, 1);
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 37 + 5 + salt * 91);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int k;
        prev_ce_n = 1; prev_done = 0; run_len = 0;
        viol_order = 0; viol_bus = 0; viol_addr = 0; viol_done = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ce_n && we_n && oe_n, "R1", "strobes in reset", {ce_n, we_n, oe_n}, 7);
        check(dq === {DW{1'bz}}, "R1", "bus released in reset", 0, 0);
        check(busy, "R1", "busy in reset", busy, 1);
        rst_n = 1;
        k = 0;
        while (busy && k < 100) begin @(negedge clk); k++; end
        check(k >= RC && k <= RC + 4, "R7", "power-up lockout length", k, RC);

        // R9: write every location, then read every location
        for (int a = 0; a < DEPTH; a++) begin
            access(1, AW'(a), pat(a, 0), rd);
            shadow[a] = pat(a, 0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            access(0, AW'(a), 8'h00, rd);
            check(rd === shadow[a], "R9", "readback", rd, shadow[a]);
        end
        // second pattern over a subset
        for (int a = 0; a < DEPTH; a += 5) begin
            access(1, AW'(a), pat(a, 1), rd);
            shadow[a] = pat(a, 1);
            access(0, AW'(a), 8'h00, rd);
            check(rd === shadow[a], "R3", "rewrite readback", rd, shadow[a]);
        end

        // R8: stray request during an access is dropped
        while (busy) @(negedge clk);
        exp_addr = 6'd3;
        req_valid = 1; req_write = 1; req_addr = 6'd3; req_wdata = 8'hA5;
        @(negedge clk);
        req_addr = 6'd10; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 0;
        k = 0;
        while (!done && k < 40) begin @(negedge clk); k++; end
        shadow[3] = 8'hA5;
        repeat (2) @(negedge clk);
        check(ce_n && !busy, "R8", "no second access", {ce_n, busy}, 2);
        access(0, 6'd10, 8'h00, rd);
        check(rd === shadow[10], "R8", "stray write dropped", rd, shadow[10]);
        access(0, 6'd3, 8'h00, rd);
        check(rd === 8'hA5, "R8", "first write kept", rd, 8'hA5);

        // R6: supply fail during write strobe
        while (busy) @(negedge clk);
        exp_addr = 6'd20;
        req_valid = 1; req_write = 1; req_addr = 6'd20; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 0;
        while (we_n) @(negedge clk);
        pwr_fail = 1;
        k = 0;
        while (!(ce_n && we_n && oe_n) && k < 10) begin
            @(negedge clk); k++;
            check(!done, "R6", "no completion on abort", done, 0);
        end
        check(k <= 3, "R6", "strobe release delay", k, 3);
        repeat (10) begin
            @(negedge clk);
            check(busy && ce_n && !done, "R7", "locked while failing", {busy, ce_n, done}, 6);
        end
        // request during fail is ignored
        req_valid = 1; req_write = 1; req_addr = 6'd30; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 0;
        pwr_fail = 0;
        k = 0;
        while (busy && k < 100) begin
            @(negedge clk); k++;
            if (!ce_n) check(0, "R7", "strobe during recovery", 0, 1);
            if (k == RC / 2) begin
                req_valid = 1;
                @(negedge clk); k++;
                req_valid = 0;
            end
        end
        check(k >= RC && k <= RC + 4, "R7", "recovery length", k, RC);
        repeat (3) @(negedge clk);
        check(ce_n, "R8", "locked request not replayed", ce_n, 1);
        access(0, 6'd30, 8'h00, rd);
        check(rd === shadow[30], "R7", "locked write dropped", rd, shadow[30]);

        // R6: supply fail during read strobe
        while (busy) @(negedge clk);
        exp_addr = 6'd7;
        req_valid = 1; req_write = 0; req_addr = 6'd7;
        @(negedge clk);
        req_valid = 0;
        while (oe_n) @(negedge clk);
        pwr_fail = 1;
        k = 0;
        while (!(ce_n && oe_n) && k < 10) begin
            @(negedge clk); k++;
            check(!done, "R6", "no read completion on abort", done, 0);
        end
        check(k <= 3, "R6", "read strobe release delay", k, 3);
        repeat (4) @(negedge clk);
        pwr_fail = 0;
        while (busy) @(negedge clk);
        access(0, 6'd7, 8'h00, rd);
        check(rd === shadow[7], "R3", "read after recovery", rd, shadow[7]);

        repeat (4) @(negedge clk);
        check(viol_order == 0, "R2", "strobe ordering violations", viol_order, 0);
        check(viol_bus == 0, "R4", "bus driven while idle", viol_bus, 0);
        check(viol_addr == 0, "R9", "address changes in strobe", viol_addr, 0);
        check(viol_done == 0, "R5", "long completion pulses", viol_done, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule